// File: doc/BRIEF.md
# DS3 C-bit Parity Overhead Inserter

This block produces a serial DS3 transmit stream in C-bit parity format, one line bit per clock. A position counter walks the 4760-bit multiframe. At each payload position the block raises a request and takes one bit from the system side. At each overhead position it inserts a bit that it builds itself: framing bits, alarm bits, parity, the format marker, far-end status and data-link bits.

The multiframe has seven 680-bit subframes. Each subframe has eight 85-bit blocks, and each block is one overhead bit followed by 84 payload bits. The line bit, an overhead marker and a start-of-multiframe pulse are registered. They appear one clock after the cycle in which the counter stood at that position. Parity over one multiframe's payload is held and inserted into the following multiframe.

Top module: `ds3_cbit_ohins`

## Requirements
- R1: A multiframe is 4760 positions long. `tx_mfs` is high for position 0 only and recurs every 4760 cycles. Within each 85-position block, position 0 is overhead and positions 1..84 are payload, so each multiframe has 4704 payload positions. `pay_req` is high exactly at payload positions.
- R2: The line output has a latency of one clock. For a payload position, `tx_bit` equals the `pay_bit` presented while `pay_req` was high. `tx_oh` is 1 for overhead positions and 0 for payload positions.
- R3: Within every subframe, blocks 2 and 8 carry a 1 and blocks 4 and 6 carry a 0. Block 1 of subframes 5, 6 and 7 carries 0, 1, 0 respectively.
- R4: Block 1 of subframes 1 and 2 carries 0 while any of `rx_los`, `rx_oof` or `rx_ais` is high. Otherwise it carries `sw_xbit`.
- R5: Block 1 of subframes 3 and 4 carries the XOR of all payload bits of the previous multiframe. In the first multiframe after reset it carries 0.
- R6: Blocks 3, 5 and 7 of subframe 3 carry the same parity value as R5.
- R7: In subframe 1, block 3 carries 1 (format marker), block 5 carries 1, and block 7 carries `feac_bit`.
- R8: Blocks 3, 5 and 7 of subframes 2, 6 and 7 carry 1.
- R9: Blocks 3, 5 and 7 of subframe 5 carry `dl_bit` and pulse `dl_req` while `dl_en` is high. While `dl_en` is low they carry 1, and `dl_req` stays low.
- R10: Blocks 3, 5 and 7 of subframe 4 carry `febe_bit`.
- R11: While `rst` is high, `tx_bit`, `tx_oh`, `tx_mfs` and `dl_req` are 0, and after reset the counter starts at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| pay_bit | input | 1 | Payload bit from the system side, taken when `pay_req` is high |
| pay_req | output | 1 | Current position is payload |
| sw_xbit | input | 1 | Software value for the far-end alarm bits |
| rx_los | input | 1 | Receive loss-of-signal defect |
| rx_oof | input | 1 | Receive out-of-frame defect |
| rx_ais | input | 1 | Receive alarm-indication defect |
| dl_en | input | 1 | Data-link source enable |
| dl_bit | input | 1 | Data-link bit, taken when `dl_req` is high |
| dl_req | output | 1 | Current position consumes a data-link bit |
| febe_bit | input | 1 | Far-end block error value |
| feac_bit | input | 1 | Far-end alarm and control value |
| tx_bit | output | 1 | Serial line bit |
| tx_oh | output | 1 | `tx_bit` is an overhead bit |
| tx_mfs | output | 1 | `tx_bit` is position 0 of a multiframe |

## Verification
The hardest case to reach is the carry of parity across a multiframe boundary. It needs a full 4760-cycle frame of known payload before the next frame's parity bits can be checked, and a frame with an even count of ones must show 0 after a frame that showed 1. The stimulus runs five consecutive multiframes with different payload patterns: random, all ones, random, alternating and random. The bench XORs the payload it drove and predicts both parity positions of each following frame. Alarm defects, the data-link enable and the status inputs change at random every cycle, so each of their overhead slots is seen with both values.

// File: rtl/ds3_ohins_pkg.sv
package ds3_ohins_pkg;
  typedef enum logic [3:0] {
    OH_XALM, OH_PAR, OH_MFR, OH_FONE, OH_FZERO,
    OH_FMT, OH_RSV, OH_FEAC, OH_FILL, OH_CPAR, OH_FEBE, OH_DLNK
  } oh_kind_t;
endpackage

// File: rtl/ds3_mf_pos.sv
module ds3_mf_pos #(
  parameter int SUBFRAMES  = 7,
  parameter int BLOCKS     = 8,
  parameter int BLOCK_BITS = 85,
  parameter int SFW = $clog2(SUBFRAMES),
  parameter int BKW = $clog2(BLOCKS),
  parameter int BTW = $clog2(BLOCK_BITS)
) (
  input  logic           clk,
  input  logic           rst,
  output logic [SFW-1:0] sf_idx,
  output logic [BKW-1:0] blk_idx,
  output logic           is_oh,
  output logic           mf_start,
  output logic           mf_last
);
  localparam logic [SFW-1:0] SF_MAX  = SFW'(SUBFRAMES - 1);
  localparam logic [BKW-1:0] BLK_MAX = BKW'(BLOCKS - 1);
  localparam logic [BTW-1:0] BIT_MAX = BTW'(BLOCK_BITS - 1);

  logic [BTW-1:0] bit_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      sf_idx  <= '0;
      blk_idx <= '0;
      bit_idx <= '0;
    end else if (bit_idx == BIT_MAX) begin
      bit_idx <= '0;
      if (blk_idx == BLK_MAX) begin
        blk_idx <= '0;
        sf_idx  <= (sf_idx == SF_MAX) ? '0 : sf_idx + 1'b1;
      end else begin
        blk_idx <= blk_idx + 1'b1;
      end
    end else begin
      bit_idx <= bit_idx + 1'b1;
    end
  end

  assign is_oh    = (bit_idx == '0);
  assign mf_start = is_oh && (blk_idx == '0) && (sf_idx == '0);
  assign mf_last  = (bit_idx == BIT_MAX) && (blk_idx == BLK_MAX) && (sf_idx == SF_MAX);
endmodule

// File: rtl/ds3_oh_map.sv
module ds3_oh_map
  import ds3_ohins_pkg::*;
#(
  parameter int SFW = 3,
  parameter int BKW = 3
) (
  input  logic [SFW-1:0] sf_idx,
  input  logic [BKW-1:0] blk_idx,
  output oh_kind_t       kind
);
  oh_kind_t cbit_kind;

  // C-bit meaning depends on subframe; block picks C1/C2/C3 in subframe 1
  always_comb begin
    case (sf_idx)
      SFW'(0): begin
        if (blk_idx == BKW'(2))      cbit_kind = OH_FMT;
        else if (blk_idx == BKW'(4)) cbit_kind = OH_RSV;
        else                         cbit_kind = OH_FEAC;
      end
      SFW'(2):  cbit_kind = OH_CPAR;
      SFW'(3):  cbit_kind = OH_FEBE;
      SFW'(4):  cbit_kind = OH_DLNK;
      default:  cbit_kind = OH_FILL;
    endcase
  end

  always_comb begin
    case (blk_idx)
      BKW'(0): begin
        if (sf_idx < SFW'(2))      kind = OH_XALM;
        else if (sf_idx < SFW'(4)) kind = OH_PAR;
        else                       kind = OH_MFR;
      end
      BKW'(1), BKW'(7): kind = OH_FONE;
      BKW'(3), BKW'(5): kind = OH_FZERO;
      default:          kind = cbit_kind;
    endcase
  end
endmodule

// File: rtl/ds3_par_acc.sv
module ds3_par_acc (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic din,
  input  logic frame_end,
  output logic par_prev
);
  logic acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= 1'b0;
      par_prev <= 1'b0;
    end else if (frame_end) begin
      par_prev <= acc ^ (take & din);
      acc      <= 1'b0;
    end else if (take) begin
      acc <= acc ^ din;
    end
  end
endmodule

// File: rtl/ds3_cbit_ohins.sv
module ds3_cbit_ohins
  import ds3_ohins_pkg::*;
#(
  parameter int SUBFRAMES  = 7,
  parameter int BLOCKS     = 8,
  parameter int BLOCK_BITS = 85
) (
  input  logic clk,
  input  logic rst,
  input  logic pay_bit,
  output logic pay_req,
  input  logic sw_xbit,
  input  logic rx_los,
  input  logic rx_oof,
  input  logic rx_ais,
  input  logic dl_en,
  input  logic dl_bit,
  output logic dl_req,
  input  logic febe_bit,
  input  logic feac_bit,
  output logic tx_bit,
  output logic tx_oh,
  output logic tx_mfs
);
  localparam int SFW = $clog2(SUBFRAMES);
  localparam int BKW = $clog2(BLOCKS);

  logic [SFW-1:0] sf_idx;
  logic [BKW-1:0] blk_idx;
  logic           is_oh, mf_start, mf_last;
  logic           par_prev, oh_val, defect, x_slot;
  oh_kind_t       kind;

  ds3_mf_pos #(.SUBFRAMES(SUBFRAMES), .BLOCKS(BLOCKS), .BLOCK_BITS(BLOCK_BITS)) u_pos (
    .clk(clk), .rst(rst), .sf_idx(sf_idx), .blk_idx(blk_idx),
    .is_oh(is_oh), .mf_start(mf_start), .mf_last(mf_last)
  );

  ds3_oh_map #(.SFW(SFW), .BKW(BKW)) u_map (
    .sf_idx(sf_idx), .blk_idx(blk_idx), .kind(kind)
  );

  ds3_par_acc u_par (
    .clk(clk), .rst(rst), .take(pay_req), .din(pay_bit),
    .frame_end(mf_last), .par_prev(par_prev)
  );

  assign defect  = rx_los | rx_oof | rx_ais;
  assign pay_req = ~is_oh;
  assign x_slot  = is_oh && (kind == OH_XALM);
  assign dl_req  = is_oh && (kind == OH_DLNK) && dl_en;

  always_comb begin
    case (kind)
      OH_XALM:         oh_val = sw_xbit & ~defect;
      OH_PAR, OH_CPAR: oh_val = par_prev;
      OH_MFR:          oh_val = (sf_idx == SFW'(5));
      OH_FZERO:        oh_val = 1'b0;
      OH_FEAC:         oh_val = feac_bit;
      OH_FEBE:         oh_val = febe_bit;
      OH_DLNK:         oh_val = dl_en ? dl_bit : 1'b1;
      default:         oh_val = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_bit <= 1'b0;
      tx_oh  <= 1'b0;
      tx_mfs <= 1'b0;
    end else begin
      tx_bit <= is_oh ? oh_val : pay_bit;
      tx_oh  <= is_oh;
      tx_mfs <= mf_start;
    end
  end
endmodule

// File: rtl/ds3_ohins_chk.sv
module ds3_ohins_chk #(
  parameter int MF_BITS = 4760
) (
  input logic clk,
  input logic rst,
  input logic pay_req,
  input logic dl_req,
  input logic dl_en,
  input logic tx_bit,
  input logic tx_oh,
  input logic tx_mfs,
  input logic x_slot,
  input logic defect
);
  localparam int CW = $clog2(MF_BITS);

  logic          armed, seen_mfs;
  logic [CW-1:0] since_mfs;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      seen_mfs  <= 1'b0;
      since_mfs <= '0;
    end else begin
      armed <= 1'b1;
      if (tx_mfs) begin
        seen_mfs  <= 1'b1;
        since_mfs <= '0;
      end else begin
        since_mfs <= since_mfs + 1'b1;
      end
    end
  end

  p_mf_period_r1: assert property (@(posedge clk) disable iff (rst)
    (tx_mfs && seen_mfs) |-> (since_mfs == CW'(MF_BITS - 1)));

  p_oh_marker_r2: assert property (@(posedge clk) disable iff (rst)
    armed |-> (tx_oh == !$past(pay_req)));

  p_xbit_alarm_r4: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(x_slot) && $past(defect)) |-> !tx_bit);

  p_dl_req_r9: assert property (@(posedge clk) disable iff (rst)
    dl_req |-> (dl_en && !pay_req));
endmodule

bind ds3_cbit_ohins ds3_ohins_chk u_chk (
  .clk(clk), .rst(rst), .pay_req(pay_req), .dl_req(dl_req), .dl_en(dl_en),
  .tx_bit(tx_bit), .tx_oh(tx_oh), .tx_mfs(tx_mfs), .x_slot(x_slot), .defect(defect)
);

// File: tb/test_ds3_cbit_ohins.sv
module test_ds3_cbit_ohins;
  localparam int CLK_PERIOD = 10;
  localparam int MF   = 4760;
  localparam int SFB  = 680;
  localparam int BLKB = 85;
  localparam int NFR  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pay_bit = 1'b0, sw_xbit = 1'b0, rx_los = 1'b0, rx_oof = 1'b0, rx_ais = 1'b0;
  logic dl_en = 1'b0, dl_bit = 1'b0, febe_bit = 1'b0, feac_bit = 1'b0;
  logic pay_req, dl_req, tx_bit, tx_oh, tx_mfs;

  int checks = 0, errors = 0;
  bit done = 0;

  ds3_cbit_ohins i_ds3_cbit_ohins (
    .clk(clk), .rst(rst), .pay_bit(pay_bit), .pay_req(pay_req), .sw_xbit(sw_xbit),
    .rx_los(rx_los), .rx_oof(rx_oof), .rx_ais(rx_ais), .dl_en(dl_en), .dl_bit(dl_bit),
    .dl_req(dl_req), .febe_bit(febe_bit), .feac_bit(feac_bit),
    .tx_bit(tx_bit), .tx_oh(tx_oh), .tx_mfs(tx_mfs)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp, input int pos);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at position %0d: actual %0d expected %0d", req, pos, act, exp);
    end
  endtask

  // subframe s (1..7) and block k (1..8) of a position
  function automatic int sub_of(int p); return p / SFB + 1; endfunction
  function automatic int blk_of(int p); return (p % SFB) / BLKB + 1; endfunction
  function automatic bit is_pay(int p); return (p % BLKB) != 0; endfunction

  function automatic string req_of(int p);
    int s = sub_of(p), k = blk_of(p);
    if (is_pay(p)) return "R2";
    if (k == 2 || k == 8 || k == 4 || k == 6) return "R3";
    if (k == 1) return (s <= 2) ? "R4" : (s <= 4) ? "R5" : "R3";
    case (s)
      1: return "R7";
      3: return "R6";
      4: return "R10";
      5: return "R9";
      default: return "R8";
    endcase
  endfunction

  function automatic bit exp_oh(int p, bit dfct, bit sw, bit par, bit den, bit dbit, bit febe, bit feac);
    int s = sub_of(p), k = blk_of(p);
    if (k == 2 || k == 8) return 1'b1;
    if (k == 4 || k == 6) return 1'b0;
    if (k == 1) begin
      if (s <= 2) return dfct ? 1'b0 : sw;
      if (s <= 4) return par;
      return s == 6;
    end
    case (s)
      1: return (k == 7) ? feac : 1'b1;
      3: return par;
      4: return febe;
      5: return den ? dbit : 1'b1;
      default: return 1'b1;
    endcase
  endfunction

  initial begin
    bit exp_bit, exp_oh_f, exp_mfs, par_acc, par_hold, dfct, have_prev;
    int prev_pos;
    void'($urandom(32'd1234));
    par_acc = 0; par_hold = 0; have_prev = 0; exp_bit = 0; exp_oh_f = 0; exp_mfs = 0; prev_pos = 0;
    repeat (3) @(negedge clk);
    // R11: outputs held low under reset
    check(tx_bit == 0 && tx_oh == 0 && tx_mfs == 0 && dl_req == 0, "R11",
          {tx_bit, tx_oh, tx_mfs, dl_req}, 0, -1);
    rst = 1'b0;
    for (int f = 0; f < NFR; f++) begin
      for (int p = 0; p < MF; p++) begin
        // outputs of the previous position
        if (have_prev) begin
          check(tx_bit == exp_bit, req_of(prev_pos), tx_bit, exp_bit, prev_pos);
          check(tx_oh == exp_oh_f, "R2", tx_oh, exp_oh_f, prev_pos);
          check(tx_mfs == exp_mfs, "R1", tx_mfs, exp_mfs, prev_pos);
        end
        // drive this position
        case (f % 4)
          1: pay_bit = 1'b1;
          3: pay_bit = p[0];
          default: pay_bit = 1'($urandom);
        endcase
        sw_xbit  = 1'($urandom);
        rx_los   = ($urandom % 8) == 0;
        rx_oof   = ($urandom % 8) == 0;
        rx_ais   = ($urandom % 8) == 0;
        dl_en    = 1'($urandom);
        dl_bit   = 1'($urandom);
        febe_bit = 1'($urandom);
        feac_bit = 1'($urandom);
        #1;
        dfct = rx_los | rx_oof | rx_ais;
        check(pay_req == is_pay(p), "R1", pay_req, is_pay(p), p);
        check(dl_req == (!is_pay(p) && sub_of(p) == 5 && (blk_of(p) % 2 == 1) && blk_of(p) > 1 && dl_en),
              "R9", dl_req, dl_en, p);
        if (is_pay(p)) begin
          exp_bit = pay_bit;
          par_acc = par_acc ^ pay_bit;
        end else begin
          exp_bit = exp_oh(p, dfct, sw_xbit, par_hold, dl_en, dl_bit, febe_bit, feac_bit);
        end
        exp_oh_f = !is_pay(p);
        exp_mfs  = (p == 0);
        prev_pos = p;
        have_prev = 1;
        if (p == MF - 1) begin
          // R5 R6: result used in the next frame only
          par_hold = par_acc;
          par_acc  = 0;
        end
        @(negedge clk);
      end
    end
    check(tx_bit == exp_bit, req_of(prev_pos), tx_bit, exp_bit, prev_pos);
    check(tx_mfs == 0, "R1", tx_mfs, 0, prev_pos);
    @(negedge clk);
    // R1: next multiframe marker after the last position
    check(tx_mfs == 1, "R1", tx_mfs, 1, 0);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule